// File: doc/BRIEF.md
# Bitfield Extract and Insert Unit

This unit carries out bitfield operations on memory. A field is named by a byte address, a signed bit offset and a width. Bit 0 of a byte is its most significant bit, and fields run in big-endian order across bytes. In the cycle a request is presented, the unit normalises the offset. It then drives the aligned load address and a byte-count code to an external load/store port. That port returns the loaded bytes, right-justified in a 64-bit window, within the same cycle.

On the next rising edge the unit registers its results:
- the rewritten window for write-back, together with a write-back request and the store address;
- the result value;
- the field's top bit, which the caller uses for the N flag.

Seven operations are supported. They are unsigned extract, signed extract, insert, change, clear, set and find-first-one. A two-state sequencer governs when the results are valid. Its states are ST_IDLE and ST_DONE. The transition ST_IDLE to ST_DONE is taken on a valid request. ST_DONE stays in ST_DONE on a further valid request and returns to ST_IDLE otherwise.

Top module: `bfu_top`

## Requirements
- R1: A width input of 0 selects a 32-bit field. Any other value 1 to 31 is used as given.
- R2: The field starts at bit address in_addr*8 + in_ofs, with in_ofs taken as signed. The start byte is in_addr plus floor(in_ofs/8), and the bit within that byte is in_ofs mod 8, which is never negative.
- R3: ld_span equals (bit-in-byte + width - 1)/8, a value from 0 to 4. The load size is 1, 2, 4, 4 or 8 bytes for ld_span 0, 1, 2, 3 or 4 respectively. For span 2, an odd start byte is moved down by one byte. For span 4, the start byte is rounded down to a multiple of 4. Otherwise ld_addr is the start byte. wb_addr and wb_span repeat the load address and code of the request.
- R4: Opcode 0 (unsigned extract) returns the field zero-extended to 32 bits and requests no write-back.
- R5: Opcode 1 (signed extract) returns the field sign-extended from its top bit and requests no write-back.
- R6: Opcode 2 (insert) writes the low width bits of in_val into the field and leaves every other bit of memory unchanged. It returns in_val shifted left by 32 - width.
- R7: Opcode 3 inverts the field, opcode 4 clears it and opcode 5 fills it with ones. Each of the three returns the field's prior contents left-justified in 32 bits.
- R8: Opcode 6 (find-first-one) returns in_ofs plus the index of the first set bit counted from the field's top. When the field is all zero it returns in_ofs plus the width. It requests no write-back.
- R9: res_n is the top bit of the field as read. For insert it is instead the top bit of the inserted value.
- R10: out_valid is high exactly in the cycle after each cycle with in_valid high. wb_req is high only together with out_valid, and only for opcodes 2 to 5.
- R11: Opcode 7 is reserved. It gives res_value 0 and res_n 0, requests no write-back and leaves memory unchanged.
- R12: While reset is asserted, out_valid and wb_req are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| in_valid | input | 1 | Request present this cycle |
| in_op | input | 3 | Operation code (0 to 7) |
| in_addr | input | ADDR_W | Byte address of the field base |
| in_ofs | input | 32 | Signed bit offset |
| in_width | input | 5 | Field width, 0 meaning 32 |
| in_val | input | 32 | Insert operand |
| ld_addr | output | ADDR_W | Aligned load address, combinational |
| ld_span | output | 3 | Load size code, combinational |
| mem_data | input | 64 | Loaded bytes, big-endian, right-justified |
| out_valid | output | 1 | Registered results valid |
| wb_req | output | 1 | Write-back required |
| wb_addr | output | ADDR_W | Write-back address |
| wb_span | output | 3 | Write-back size code |
| wb_data | output | 64 | Window to store, right-justified |
| res_value | output | 32 | Operation result |
| res_n | output | 1 | Field top bit for the N flag |

## Verification
ld_addr and ld_span depend only on the current request and settle in the same cycle. The bench therefore drives a request at a falling edge and checks the load address a moment later, before the next rising edge. All other outputs pass through one register. They are sampled at the falling edge that follows the single rising edge after the request. The stored window is then written into the bench's memory model, and the model is compared byte by byte with a reference built bit by bit. Back-to-back requests confirm that each result appears exactly one edge after its own request, and that out_valid drops one edge after in_valid does.

// File: rtl/bfu_pkg.sv
package bfu_pkg;
    localparam int WIN_W   = 64;
    localparam int FIELD_W = 32;

    typedef enum logic [2:0] {
        OP_EXTU = 3'd0,
        OP_EXTS = 3'd1,
        OP_INS  = 3'd2,
        OP_CHG  = 3'd3,
        OP_CLR  = 3'd4,
        OP_SET  = 3'd5,
        OP_FFO  = 3'd6,
        OP_RSVD = 3'd7
    } bf_op_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_DONE = 1'b1
    } bf_state_e;
endpackage

// File: rtl/bfu_locate.sv
module bfu_locate #(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [31:0]       ofs_i,
    input  logic [4:0]        width_i,
    output logic [ADDR_W-1:0] ld_addr_o,
    output logic [2:0]        span_o,
    output logic [5:0]        pos_o,
    output logic [5:0]        len_o
);
    logic signed [31:0] byte_step;
    logic [ADDR_W-1:0]  start_byte;
    logic [2:0]         bit_in_byte;
    logic [6:0]         last_bit;

    always_comb begin
        len_o       = (width_i == 5'd0) ? 6'd32 : {1'b0, width_i};
        // floor division by 8 and a non-negative remainder in one step
        byte_step   = $signed(ofs_i) >>> 3;
        start_byte  = addr_i + ADDR_W'(byte_step);
        bit_in_byte = ofs_i[2:0];
        last_bit    = {4'd0, bit_in_byte} + {1'b0, len_o} - 7'd1;
        span_o      = last_bit[5:3];
        ld_addr_o   = start_byte;
        pos_o       = {3'd0, bit_in_byte};
        unique case (span_o)
            3'd0: pos_o = 6'd56 + {3'd0, bit_in_byte};
            3'd1: pos_o = 6'd48 + {3'd0, bit_in_byte};
            3'd2: begin
                if (start_byte[0]) begin
                    ld_addr_o = start_byte - ADDR_W'(1);
                    pos_o     = 6'd40 + {3'd0, bit_in_byte};
                end else begin
                    pos_o     = 6'd32 + {3'd0, bit_in_byte};
                end
            end
            3'd3: pos_o = 6'd32 + {3'd0, bit_in_byte};
            3'd4: begin
                ld_addr_o = {start_byte[ADDR_W-1:2], 2'b00};
                pos_o     = {3'd0, bit_in_byte} + {1'b0, start_byte[1:0], 3'b000};
            end
            default: pos_o = {3'd0, bit_in_byte};
        endcase
    end
endmodule

// File: rtl/bfu_exec.sv
module bfu_exec
    import bfu_pkg::*;
(
    input  bf_op_e            op_i,
    input  logic [WIN_W-1:0]  data_i,
    input  logic [31:0]       val_i,
    input  logic [31:0]       ofs_i,
    input  logic [5:0]        pos_i,
    input  logic [5:0]        len_i,
    output logic [WIN_W-1:0]  new_data_o,
    output logic [31:0]       result_o,
    output logic              flag_n_o,
    output logic              wr_o
);
    function automatic logic [5:0] lead_zeros(input logic [31:0] v);
        logic [5:0] cnt;
        logic       hit;
        cnt = 6'd0;
        hit = 1'b0;
        for (int i = 31; i >= 0; i--) begin
            if (!hit) begin
                if (v[i]) hit = 1'b1;
                else      cnt = cnt + 6'd1;
            end
        end
        return cnt;
    endfunction

    logic [6:0]       cut;
    logic [5:0]       cut32;
    logic [WIN_W-1:0] mask;
    logic [WIN_W-1:0] aligned;
    logic [WIN_W-1:0] zext;
    logic [WIN_W-1:0] sext;
    logic [WIN_W-1:0] ins_bits;
    logic [31:0]      old_lj;
    logic [31:0]      ins_lj;
    logic [31:0]      ffo_val;

    always_comb begin
        cut      = 7'd64 - {1'b0, len_i};
        cut32    = 6'd32 - len_i;
        mask     = ({WIN_W{1'b1}} << cut) >> pos_i;
        aligned  = data_i << pos_i;
        old_lj   = aligned[63:32] & ({32{1'b1}} << cut32);
        zext     = aligned >> cut;
        sext     = $unsigned($signed(aligned) >>> cut);
        ins_bits = ({32'd0, val_i} << cut) >> pos_i;
        ins_lj   = val_i << cut32;
        ffo_val  = ofs_i + ((old_lj == 32'd0) ? {26'd0, len_i} : {26'd0, lead_zeros(old_lj)});

        new_data_o = data_i;
        result_o   = 32'd0;
        flag_n_o   = 1'b0;
        wr_o       = 1'b0;
        unique case (op_i)
            OP_EXTU: begin
                result_o = zext[31:0];
                flag_n_o = old_lj[31];
            end
            OP_EXTS: begin
                result_o = sext[31:0];
                flag_n_o = old_lj[31];
            end
            OP_INS: begin
                new_data_o = (data_i & ~mask) | ins_bits;
                result_o   = ins_lj;
                flag_n_o   = ins_lj[31];
                wr_o       = 1'b1;
            end
            OP_CHG: begin
                new_data_o = data_i ^ mask;
                result_o   = old_lj;
                flag_n_o   = old_lj[31];
                wr_o       = 1'b1;
            end
            OP_CLR: begin
                new_data_o = data_i & ~mask;
                result_o   = old_lj;
                flag_n_o   = old_lj[31];
                wr_o       = 1'b1;
            end
            OP_SET: begin
                new_data_o = data_i | mask;
                result_o   = old_lj;
                flag_n_o   = old_lj[31];
                wr_o       = 1'b1;
            end
            OP_FFO: begin
                result_o = ffo_val;
                flag_n_o = old_lj[31];
            end
            OP_RSVD: begin
                result_o = 32'd0;
            end
            default: result_o = 32'd0;
        endcase
    end
endmodule

// File: rtl/bfu_top.sv
module bfu_top
    import bfu_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [2:0]        in_op,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic [31:0]       in_ofs,
    input  logic [4:0]        in_width,
    input  logic [31:0]       in_val,
    output logic [ADDR_W-1:0] ld_addr,
    output logic [2:0]        ld_span,
    input  logic [63:0]       mem_data,
    output logic              out_valid,
    output logic              wb_req,
    output logic [ADDR_W-1:0] wb_addr,
    output logic [2:0]        wb_span,
    output logic [63:0]       wb_data,
    output logic [31:0]       res_value,
    output logic              res_n
);
    bf_state_e   state_q, state_d;
    logic [5:0]  pos;
    logic [5:0]  len;
    logic [63:0] new_data;
    logic [31:0] result;
    logic        flag_n;
    logic        wr;

    bfu_locate #(.ADDR_W(ADDR_W)) u_locate (
        .addr_i    (in_addr),
        .ofs_i     (in_ofs),
        .width_i   (in_width),
        .ld_addr_o (ld_addr),
        .span_o    (ld_span),
        .pos_o     (pos),
        .len_o     (len)
    );

    bfu_exec u_exec (
        .op_i       (bf_op_e'(in_op)),
        .data_i     (mem_data),
        .val_i      (in_val),
        .ofs_i      (in_ofs),
        .pos_i      (pos),
        .len_i      (len),
        .new_data_o (new_data),
        .result_o   (result),
        .flag_n_o   (flag_n),
        .wr_o       (wr)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (in_valid) state_d = ST_DONE;
            ST_DONE: state_d = in_valid ? ST_DONE : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wb_req    <= 1'b0;
            wb_addr   <= '0;
            wb_span   <= 3'd0;
            wb_data   <= 64'd0;
            res_value <= 32'd0;
            res_n     <= 1'b0;
        end else if (in_valid) begin
            wb_req    <= wr;
            wb_addr   <= ld_addr;
            wb_span   <= ld_span;
            wb_data   <= new_data;
            res_value <= result;
            res_n     <= flag_n;
        end else begin
            wb_req    <= 1'b0;
        end
    end

    assign out_valid = (state_q == ST_DONE);
endmodule

// File: rtl/bfu_chk.sv
module bfu_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [2:0]        in_op,
    input logic [4:0]        in_width,
    input logic [ADDR_W-1:0] ld_addr,
    input logic [2:0]        ld_span,
    input logic              out_valid,
    input logic              wb_req,
    input logic [ADDR_W-1:0] wb_addr,
    input logic [31:0]       res_value
);
    p_wide_span_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_width == 5'd0) |-> (ld_span >= 3'd3));

    p_span_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |-> (ld_span <= 3'd4));

    p_wb_addr_r3: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (wb_addr == $past(ld_addr)));

    p_no_store_on_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (in_op == 3'd0 || in_op == 3'd1 || in_op == 3'd6)) |=> !wb_req);

    p_valid_follows_r10: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    p_valid_drops_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    p_store_needs_valid_r10: assert property (@(posedge clk) disable iff (!rst_n)
        wb_req |-> out_valid);

    p_reserved_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_op == 3'd7) |=> (!wb_req && res_value == 32'd0));
endmodule

bind bfu_top bfu_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_op     (in_op),
    .in_width  (in_width),
    .ld_addr   (ld_addr),
    .ld_span   (ld_span),
    .out_valid (out_valid),
    .wb_req    (wb_req),
    .wb_addr   (wb_addr),
    .res_value (res_value)
);

// File: tb/sim_bfu_top.sv
`timescale 1ns/1ps
module sim_bfu_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [2:0]  in_op = 3'd0;
    logic [31:0] in_addr = 32'd0;
    logic [31:0] in_ofs = 32'd0;
    logic [4:0]  in_width = 5'd1;
    logic [31:0] in_val = 32'd0;
    logic [31:0] ld_addr;
    logic [2:0]  ld_span;
    logic [63:0] mem_data;
    logic        out_valid, wb_req, res_n;
    logic [31:0] wb_addr, res_value;
    logic [2:0]  wb_span;
    logic [63:0] wb_data;

    logic [7:0] mem [32];
    logic [7:0] ref_mem [32];
    int n_chk = 0;
    int n_err = 0;
    bit done = 0;

    always #10 clk = ~clk;

    bfu_top u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
        .in_addr(in_addr), .in_ofs(in_ofs), .in_width(in_width), .in_val(in_val),
        .ld_addr(ld_addr), .ld_span(ld_span), .mem_data(mem_data),
        .out_valid(out_valid), .wb_req(wb_req), .wb_addr(wb_addr),
        .wb_span(wb_span), .wb_data(wb_data), .res_value(res_value), .res_n(res_n)
    );

    // load port model: big-endian bytes, right-justified
    always_comb begin
        logic [4:0] a;
        a = ld_addr[4:0];
        case (ld_span)
            3'd0: mem_data = {56'd0, mem[a]};
            3'd1: mem_data = {48'd0, mem[a], mem[a+5'd1]};
            3'd2, 3'd3: mem_data = {32'd0, mem[a], mem[a+5'd1], mem[a+5'd2], mem[a+5'd3]};
            3'd4: mem_data = {mem[a], mem[a+5'd1], mem[a+5'd2], mem[a+5'd3],
                              mem[a+5'd4], mem[a+5'd5], mem[a+5'd6], mem[a+5'd7]};
            default: mem_data = 64'd0;
        endcase
    end

    task automatic check(input string rq, input string what, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual=%h expected=%h", rq, what, act, exp);
        end
    endtask

    function automatic logic rbit(input int b);
        return ref_mem[(b >>> 3) & 31][7 - (b & 7)];
    endfunction

    task automatic wbit(input int b, input logic v);
        ref_mem[(b >>> 3) & 31][7 - (b & 7)] = v;
    endtask

    // reference built from absolute bit positions in memory
    task automatic model(input logic [2:0] op, input int addr, input int ofs, input int w,
                         input logic [31:0] val, output logic [31:0] er, output logic en,
                         output logic ew);
        int len;
        int s;
        int first;
        logic [31:0] f;
        logic [63:0] t;
        len = (w == 0) ? 32 : w;
        s = addr * 8 + ofs;
        f = 32'd0;
        for (int i = 0; i < len; i++) f = {f[30:0], rbit(s + i)};
        er = 32'd0; en = 1'b0; ew = 1'b0;
        case (op)
            3'd0: begin er = f; en = f[len-1]; end
            3'd1: begin
                t = {32'd0, f};
                if (f[len-1]) t = t | (~64'd0 << len);
                er = t[31:0]; en = f[len-1];
            end
            3'd2: begin
                for (int i = 0; i < len; i++) wbit(s + i, val[len-1-i]);
                er = val << (32 - len); en = val[len-1]; ew = 1'b1;
            end
            3'd3, 3'd4, 3'd5: begin
                for (int i = 0; i < len; i++)
                    wbit(s + i, (op == 3'd3) ? ~f[len-1-i] : (op == 3'd5));
                er = f << (32 - len); en = f[len-1]; ew = 1'b1;
            end
            3'd6: begin
                first = len;
                for (int i = len - 1; i >= 0; i--) if (f[len-1-i]) first = i;
                er = 32'(ofs + first); en = f[len-1];
            end
            default: ;
        endcase
    endtask

    task automatic apply_wb();
        int n;
        n = (wb_span == 3'd0) ? 1 : (wb_span == 3'd1) ? 2 : (wb_span == 3'd4) ? 8 : 4;
        for (int k = 0; k < n; k++) mem[(wb_addr + k) & 31] = wb_data[8*(n-1-k) +: 8];
    endtask

    task automatic check_mem(input string rq);
        int bad;
        bad = -1;
        for (int k = 31; k >= 0; k--) if (mem[k] !== ref_mem[k]) bad = k;
        if (bad < 0) check(rq, "memory", 64'd0, 64'd0);
        else check(rq, $sformatf("memory byte %0d", bad), {56'd0, mem[bad]}, {56'd0, ref_mem[bad]});
    endtask

    task automatic drive(input logic [2:0] op, input int addr, input int ofs, input int w,
                         input logic [31:0] val);
        in_valid = 1'b1; in_op = op; in_addr = addr; in_ofs = ofs;
        in_width = 5'(w); in_val = val;
    endtask

    task automatic run_op(input string rq, input logic [2:0] op, input int addr, input int ofs,
                          input int w, input logic [31:0] val);
        logic [31:0] er; logic en, ew;
        model(op, addr, ofs, w, val, er, en, ew);
        drive(op, addr, ofs, w, val);
        @(posedge clk); @(negedge clk);
        in_valid = 1'b0;
        check(rq, "out_valid", {63'd0, out_valid}, 64'd1);
        check(rq, "res_value", {32'd0, res_value}, {32'd0, er});
        check(rq, "res_n", {63'd0, res_n}, {63'd0, en});
        check(rq, "wb_req", {63'd0, wb_req}, {63'd0, ew});
        if (wb_req) apply_wb();
        check_mem(rq);
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        check("R12", "out_valid in reset", {63'd0, out_valid}, 64'd0);
        check("R12", "wb_req in reset", {63'd0, wb_req}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic loc(input string rq, input int addr, input int ofs, input int w,
                       input int ea, input int es);
        in_valid = 1'b0; in_addr = addr; in_ofs = ofs; in_width = 5'(w);
        #1;
        check(rq, "ld_addr", {32'd0, ld_addr}, 64'(ea));
        check(rq, "ld_span", {61'd0, ld_span}, 64'(es));
    endtask

    task automatic t_locate();
        loc("R2", 10, -3, 5, 9, 1);
        loc("R2", 6, -17, 3, 3, 1);
        loc("R2", 4, 40, 8, 9, 0);
        loc("R3", 11, 4, 20, 10, 2);
        loc("R3", 8, 4, 20, 8, 2);
        loc("R1", 13, 7, 0, 12, 4);
        @(posedge clk); @(negedge clk);
        check("R10", "out_valid idle", {63'd0, out_valid}, 64'd0);
    endtask

    task automatic t_extract();
        run_op("R4", 3'd0, 2, 3, 12, 32'd0);
        run_op("R5", 3'd1, 2, 3, 12, 32'd0);
        run_op("R1", 3'd0, 4, 5, 0, 32'd0);
        run_op("R9", 3'd1, 12, -11, 7, 32'd0);
        run_op("R3", 3'd0, 11, 4, 20, 32'd0);
    endtask

    task automatic t_insert();
        run_op("R6", 3'd2, 16, 6, 9, 32'h0000_01A5);
        run_op("R6", 3'd2, 14, 3, 5, 32'hFFFF_F0F3);
        run_op("R6", 3'd2, 20, 2, 0, 32'h89AB_CDEF);
        run_op("R4", 3'd0, 20, 2, 0, 32'd0);
    endtask

    task automatic t_modify();
        run_op("R7", 3'd3, 3, 13, 11, 32'd0);
        run_op("R7", 3'd4, 9, -2, 6, 32'd0);
        run_op("R7", 3'd5, 25, 1, 16, 32'd0);
        run_op("R7", 3'd3, 1, 30, 32, 32'd0);
    endtask

    task automatic t_ffo();
        for (int k = 28; k < 32; k++) begin mem[k] = 8'h00; ref_mem[k] = 8'h00; end
        mem[30] = 8'h04; ref_mem[30] = 8'h04;
        run_op("R8", 3'd6, 28, 3, 10, 32'd0);
        run_op("R8", 3'd6, 28, 5, 20, 32'd0);
        run_op("R8", 3'd6, 5, -6, 20, 32'd0);
    endtask

    task automatic t_reserved();
        run_op("R11", 3'd7, 6, 2, 9, 32'hFFFF_FFFF);
    endtask

    task automatic t_back_to_back();
        logic [31:0] ea, eb; logic na, nb, wa, wbq;
        model(3'd0, 7, 1, 13, 32'd0, ea, na, wa);
        model(3'd1, 17, -5, 19, 32'd0, eb, nb, wbq);
        drive(3'd0, 7, 1, 13, 32'd0);
        @(posedge clk); @(negedge clk);
        check("R10", "first result", {32'd0, res_value}, {32'd0, ea});
        check("R10", "first valid", {63'd0, out_valid}, 64'd1);
        drive(3'd1, 17, -5, 19, 32'd0);
        @(posedge clk); @(negedge clk);
        in_valid = 1'b0;
        check("R10", "second result", {32'd0, res_value}, {32'd0, eb});
        check("R10", "second valid", {63'd0, out_valid}, 64'd1);
        @(posedge clk); @(negedge clk);
        check("R10", "valid drops", {63'd0, out_valid}, 64'd0);
        check("R10", "wb_req drops", {63'd0, wb_req}, 64'd0);
    endtask

    initial begin
        for (int k = 0; k < 32; k++) begin
            mem[k] = 8'((k * 37 + 11) ^ (k << 3));
            ref_mem[k] = mem[k];
        end
        @(negedge clk);
        t_reset();
        t_locate();
        t_extract();
        t_insert();
        t_modify();
        t_ffo();
        t_reserved();
        t_back_to_back();
        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end
endmodule